// File: doc/BRIEF.md
# Four-State Processor Interrupt Sequencer

This block holds the execution state of a processor that has four fixed hardware states: a user state, an interrupt-control state, an interrupt-response state and a machine-check state. Every state owns its own bank of control and general registers in a small fast register memory. The sequencer drives a bank index that follows the state, so changing state never saves or restores any register.

The sequencer watches 32 prioritised interrupt lines, a supervisor-call request, a machine-check input, an analysis-done input from the interrupt-control routine, and a return request. It steps between the states on the clock edge that follows a request. It latches the number of the condition that won into a cause register and raises a one-cycle strobe whenever the state changes. Decoding instructions and running the service software are left to the surrounding processor.

Top module: `intr_state_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after it, state is user (code 0), bank is 0, cause is 0 and chg is 0.
- R2: In the user state, an edge with at least one effective request moves state to control (code 2). The cause takes the lowest-numbered effective condition. Effective requests are the enabled irq lines together with condition 2 when svc_req is high.
- R3: When vm_en is 0, irq lines 29, 30 and 31 are masked and cannot cause a transition. When vm_en is 1, they act like any other line.
- R4: svc_req in the user, response (code 1) or machine-check (code 3) state moves state to control. From response or machine-check the cause becomes 2. From the user state the cause follows R2. In the control state svc_req is ignored.
- R5: In the control state, ana_done moves state to response on the next edge. Without it, and without mchk, the state stays in control.
- R6: mchk moves state to machine-check from any state on the next edge, ahead of every other input. It leaves the cause unchanged.
- R7: In the response state, ret_req with no svc_req and no mchk moves state to user.
- R8: In the machine-check state, ret_req moves state to user only when recov_ok is 1. Otherwise the state stays in machine-check.
- R9: The irq lines take effect only in the user state. In every other state they are ignored and stay pending, and they are taken once the user state is back.
- R10: bank always equals the state code: user 0, response 1, control 2, machine-check 3.
- R11: chg is 1 for exactly the cycle after an edge that changed the state, and 0 otherwise.
- R12: The cause changes only on an edge that enters the control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 32 | Interrupt condition lines, line 0 highest priority |
| vm_en | input | 1 | Virtual-memory mode, enables lines 29..31 |
| svc_req | input | 1 | Supervisor-call request |
| mchk | input | 1 | Hardware malfunction |
| ana_done | input | 1 | Control-state analysis finished |
| ret_req | input | 1 | Return request |
| recov_ok | input | 1 | Recovery complete flag |
| state | output | 2 | Current state code |
| bank | output | 2 | Active register bank |
| cause | output | 5 | Latched condition number |
| chg | output | 1 | One-cycle state-change strobe |

## Verification
Random cycles use sparse irq vectors ANDed from several random words, so that single and multiple pending lines both occur often. Those runs tell the lowest-number priority apart from any other ordering. Directed runs hold line 31 high with virtual-memory mode first off and then on, which separates the mask from ordinary priority. Other directed runs keep lines asserted through the control, response and machine-check states, showing that lines are ignored there but stay pending, and they pair ret_req with recov_ok both high and low. A supervisor call issued together with irq line 0, and then alone, checks that its fixed condition number competes in the priority like any other line.

// File: rtl/intr_state_seq.sv
module intr_state_seq #(
  parameter int NSRC   = 32,
  parameter int NVM    = 3,
  parameter int SVC_ID = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          irq,
  input  logic                     vm_en,
  input  logic                     svc_req,
  input  logic                     mchk,
  input  logic                     ana_done,
  input  logic                     ret_req,
  input  logic                     recov_ok,
  output logic [1:0]               state,
  output logic [1:0]               bank,
  output logic [$clog2(NSRC)-1:0]  cause,
  output logic                     chg
);
  localparam int CW = $clog2(NSRC);
  localparam logic [1:0] S_USR = 2'd0, S_RSP = 2'd1, S_CTL = 2'd2, S_MCK = 2'd3;
  localparam logic [NSRC-1:0] VM_MASK = {{NVM{1'b1}}, {(NSRC-NVM){1'b0}}};
  localparam logic [CW-1:0] SVC_CODE = CW'(SVC_ID);

  logic [NSRC-1:0] eff;
  logic [CW-1:0]   win;
  logic [1:0]      nxt;
  logic [CW-1:0]   nxt_cause;

  assign eff = (irq & ~(vm_en ? '0 : VM_MASK)) | (NSRC'(svc_req) << SVC_ID);

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (eff[i]) win = CW'(i);
  end

  always_comb begin
    nxt = state;
    nxt_cause = cause;
    if (mchk) nxt = S_MCK;
    else case (state)
      S_USR: if (|eff) begin nxt = S_CTL; nxt_cause = win; end
      S_RSP: if (svc_req) begin nxt = S_CTL; nxt_cause = SVC_CODE; end
             else if (ret_req) nxt = S_USR;
      S_CTL: if (ana_done) nxt = S_RSP;
      default: if (svc_req) begin nxt = S_CTL; nxt_cause = SVC_CODE; end
               else if (ret_req && recov_ok) nxt = S_USR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_USR;
      cause <= '0;
      chg   <= 1'b0;
    end else begin
      state <= nxt;
      cause <= nxt_cause;
      chg   <= (nxt != state);
    end
  end

  assign bank = state;
endmodule

// File: rtl/intr_state_seq_chk.sv
module intr_state_seq_chk #(
  parameter int NSRC = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSRC-1:0]         irq,
  input logic                    vm_en,
  input logic                    svc_req,
  input logic                    mchk,
  input logic                    ana_done,
  input logic                    ret_req,
  input logic                    recov_ok,
  input logic [1:0]              state,
  input logic [$clog2(NSRC)-1:0] cause,
  input logic                    chg
);
  // R11
  strobe_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state)) |-> chg);

  // R6
  mchk_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mchk |=> (state == 2'd3));

  // R5
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && !mchk && !ana_done) |=> (state == 2'd2));

  // R8
  mck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && !mchk && !svc_req && !recov_ok) |=> (state == 2'd3));

  // R3
  vm_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !vm_en && !svc_req && !mchk && irq[NSRC-4:0] == '0) |=> (state == 2'd0));

  // R12
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != $past(cause)) |-> (state == 2'd2 && $past(state) != 2'd2));
endmodule

bind intr_state_seq intr_state_seq_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .vm_en(vm_en), .svc_req(svc_req),
  .mchk(mchk), .ana_done(ana_done), .ret_req(ret_req), .recov_ok(recov_ok),
  .state(state), .cause(cause), .chg(chg));

// File: tb/sim_intr_state_seq.sv
module sim_intr_state_seq;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] irq = 0;
  logic        vm_en = 0, svc_req = 0, mchk = 0, ana_done = 0, ret_req = 0, recov_ok = 0;
  logic [1:0]  state, bank;
  logic [4:0]  cause;
  logic        chg;

  int total = 0, bad = 0;
  logic [1:0] m_st = 0;
  logic [4:0] m_cause = 0;

  intr_state_seq u0 (.clk(clk), .rst_n(rst_n), .irq(irq), .vm_en(vm_en),
    .svc_req(svc_req), .mchk(mchk), .ana_done(ana_done), .ret_req(ret_req),
    .recov_ok(recov_ok), .state(state), .bank(bank), .cause(cause), .chg(chg));

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] eff_req(logic [31:0] r, logic vm, logic sv);
    logic [31:0] e = vm ? r : (r & 32'h1FFF_FFFF);
    if (sv) e[2] = 1'b1;
    return e;
  endfunction

  function automatic logic [4:0] lowest(logic [31:0] e);
    for (int i = 0; i < 32; i++) if (e[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [1:0] n = m_st;
    logic [4:0] c = m_cause;
    logic [31:0] e = eff_req(irq, vm_en, svc_req);
    string t = tag;
    if (mchk) begin n = 3; t = {tag, " R6"}; end
    else if (m_st == 0) begin
      if (e != 0) begin n = 2; c = lowest(e); t = {tag, " R2"}; end
      else t = {tag, " R3"};
    end else if (m_st == 1) begin
      if (svc_req) begin n = 2; c = 2; t = {tag, " R4"}; end
      else if (ret_req) begin n = 0; t = {tag, " R7"}; end
      else t = {tag, " R9"};
    end else if (m_st == 2) begin
      if (ana_done) begin n = 1; t = {tag, " R5"}; end
      else t = {tag, " R9"};
    end else begin
      if (svc_req) begin n = 2; c = 2; t = {tag, " R4"}; end
      else if (ret_req && recov_ok) begin n = 0; t = {tag, " R8"}; end
      else t = {tag, " R8"};
    end
    @(posedge clk); #1;
    chk({t, " state"}, 32'(state), 32'(n));
    chk({t, " R10 bank"}, 32'(bank), 32'(n));
    chk({t, " R12 cause"}, 32'(cause), 32'(c));
    chk({t, " R11 chg"}, 32'(chg), 32'(n != m_st));
    m_st = n; m_cause = c;
  endtask

  task automatic drive(logic [31:0] r, logic vm, logic sv, logic mc, logic ad,
                       logic rt, logic ro);
    @(negedge clk);
    irq = r; vm_en = vm; svc_req = sv; mchk = mc; ana_done = ad; ret_req = rt; recov_ok = ro;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 state", 32'(state), 0);
    chk("R1 cause", 32'(cause), 0);
    chk("R1 chg", 32'(chg), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 post state", 32'(state), 0);
    chk("R1 post chg", 32'(chg), 0);

    // R3: line 31 masked, then enabled
    drive(32'h8000_0000, 0, 0, 0, 0, 0, 0); step("dir-vmoff");
    drive(32'h8000_0000, 0, 0, 0, 0, 0, 0); step("dir-vmoff");
    drive(32'h8000_0000, 1, 0, 0, 0, 0, 0); step("dir-vmon");
    // R9: lines held through control, response
    drive(32'h0000_0011, 1, 0, 0, 0, 0, 0); step("dir-ctl");
    drive(32'h0000_0011, 1, 0, 0, 1, 0, 0); step("dir-ana");
    drive(32'h0000_0011, 1, 0, 0, 0, 0, 0); step("dir-rsp");
    drive(32'h0000_0011, 1, 0, 0, 0, 1, 0); step("dir-ret");
    drive(32'h0000_0011, 1, 0, 0, 0, 0, 0); step("dir-pend");
    // R6 then R8
    drive(0, 0, 0, 1, 0, 0, 0); step("dir-mchk");
    drive(32'h1, 0, 0, 0, 0, 1, 0); step("dir-norecov");
    drive(32'h1, 0, 0, 0, 0, 1, 1); step("dir-recov");
    // R4: svc together with line 0, then alone
    drive(32'h1, 0, 1, 0, 0, 0, 0); step("dir-svc0");
    drive(0, 0, 0, 0, 1, 0, 0); step("dir-ana2");
    drive(0, 0, 0, 0, 0, 1, 0); step("dir-ret2");
    drive(0, 0, 1, 0, 0, 0, 0); step("dir-svc");
    drive(0, 0, 1, 0, 0, 0, 0); step("dir-svcctl");

    for (int k = 0; k < 3000; k++) begin
      drive($urandom & $urandom & $urandom & $urandom, 1'($urandom % 2),
            ($urandom % 8) == 0, ($urandom % 25) == 0, ($urandom % 3) == 0,
            ($urandom % 3) == 0, 1'($urandom % 2));
      step("rnd");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule